// File: doc/BRIEF.md
# Indexed-Access System Timer Wrapper

This block is a free-running system timer that software reaches through only two bus locations: a data window and an index register. Software first writes the number of an internal register into the index register. Every later access to the data window then reads or writes that internal register, until the index is written again. Two internal registers exist. The control register holds a global run bit and a one-hot prescaler select. The mask register holds one interrupt enable bit per CPU.

The prescaler divides the input clock by 1, 2 or 4 to form a tick. A 64-bit counter advances once per tick while the run bit is set. Each CPU has an incoming pending event. That event reaches the CPU's interrupt output only when the CPU's mask bit is set. Software silences the timer by clearing mask bits and leaving the run bit set, so the count keeps advancing while the interrupts are quiet.

Top module: `idx_timer_ctl`

## Requirements
- R1: Bus offset 0x4 is the index register. A write stores the low 8 bits of write data. A read returns the last stored value, zero-extended, and the value after reset is 0.
- R2: A read request is answered on `bus_rdata` in the cycle after the request. `bus_rdata` holds its value until the next read and is 0 after reset. A read at any bus offset other than 0x0 and 0x4 returns 0.
- R3: Internal index 0x00 is the control register. Bit 0 is the run bit and bits 10:8 are the prescaler select. All other bits read as 0. The value after reset is 0x00000100.
- R4: The prescaler select is one-hot: bit 8 selects divide-by-1, bit 9 divide-by-2 and bit 10 divide-by-4. Counting starts on the edge that accepts the write which sets the run bit. N cycles later the count has grown by floor(N/k), and it never steps by more than 1 per cycle.
- R5: A select of 000, or any select with more than one bit set, counts as divide-by-1.
- R6: The 64-bit count holds while the run bit is clear. The write that clears the run bit still lets the count advance on the edge that accepts it, if a tick is due on that edge.
- R7: Internal index 0x30 is the mask register, with one bit per CPU in bits NCPU-1:0. It reads back what was written and is 0 after reset. Each `irq_out` bit is the matching `evt_in` bit ANDed with the matching mask bit.
- R8: With the mask cleared, `irq_out` stays 0 whatever `evt_in` does, and the count keeps advancing while the run bit is set.
- R9: A data-window read at any internal index other than 0x00 and 0x30 returns 0. A data-window write at such an index changes nothing. A write at any bus offset other than 0x0 and 0x4 changes nothing.
- R10: The index holds between data accesses, so repeated data-window accesses reach the same internal register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Single-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset (0x0 data window, 0x4 index) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| evt_in | input | NCPU | Pending event per CPU |
| irq_out | output | NCPU | Masked interrupt per CPU |
| count_out | output | CNT_W | Free-running count |

## Verification
The case that matters is a control write that clears the run bit arriving on the same edge as a due tick. The bench provokes it by issuing the disabling write immediately after a counting window, for each divider setting. It then judges the final count against floor((N+2)/k), and checks that the count stays flat for several cycles afterwards. A mask clear done while events are asserted is judged in the same way: `irq_out` must drop while the count keeps climbing.

// File: rtl/idx_timer_ctl.sv
module idx_timer_ctl #(
  parameter int NCPU     = 4,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 8,
  parameter int CNT_W    = 64,
  parameter int CTRL_IDX = 'h00,
  parameter int MASK_IDX = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCPU-1:0]   evt_in,
  output logic [NCPU-1:0]   irq_out,
  output logic [CNT_W-1:0]  count_out
);
  localparam logic [ADDR_W-1:0] WIN_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IDX_OFS = ADDR_W'(4);
  localparam int RUN_BIT = 0;
  localparam int DIV_LO  = 8;

  logic [IDX_W-1:0]  idx_q;
  logic              ctl_en;
  logic [2:0]        ctl_div;
  logic [NCPU-1:0]   irq_mask;
  logic [1:0]        pre_q;
  logic [1:0]        pre_lim;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] ctrl_word, win_word, rd_word;

  wire wr       = bus_req & bus_we;
  wire rd       = bus_req & ~bus_we;
  wire hit_win  = bus_addr == WIN_OFS;
  wire hit_idx  = bus_addr == IDX_OFS;
  wire sel_ctl  = idx_q == IDX_W'(CTRL_IDX);
  wire sel_mask = idx_q == IDX_W'(MASK_IDX);
  wire tick     = ctl_en && ((pre_q & pre_lim) == pre_lim);

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^bus_wdata;

  always_comb begin
    case (ctl_div)
      3'b010:  pre_lim = 2'b01;
      3'b100:  pre_lim = 2'b11;
      default: pre_lim = 2'b00;
    endcase
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[RUN_BIT] = ctl_en;
    ctrl_word[DIV_LO +: 3] = ctl_div;
  end

  assign win_word = sel_ctl  ? ctrl_word :
                    sel_mask ? DATA_W'(irq_mask) : '0;
  assign rd_word  = hit_win ? win_word :
                    hit_idx ? DATA_W'(idx_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      ctl_en   <= 1'b0;
      ctl_div  <= 3'b001;
      irq_mask <= '0;
    end else if (wr) begin
      if (hit_idx) idx_q <= bus_wdata[IDX_W-1:0];
      if (hit_win && sel_ctl) begin
        ctl_en  <= bus_wdata[RUN_BIT];
        ctl_div <= bus_wdata[DIV_LO +: 3];
      end
      if (hit_win && sel_mask) irq_mask <= bus_wdata[NCPU-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= ctl_en ? pre_q + 2'd1 : 2'd0;
      if (tick) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign count_out = cnt_q;
  assign irq_out   = evt_in & irq_mask;
endmodule

// File: rtl/idx_timer_ctl_chk.sv
module idx_timer_ctl_chk #(
  parameter int NCPU   = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NCPU-1:0]   evt_in,
  input logic [NCPU-1:0]   irq_out,
  input logic [CNT_W-1:0]  count_out,
  input logic              ctl_en,
  input logic [2:0]        ctl_div,
  input logic [NCPU-1:0]   irq_mask
);
  // R6
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> $stable(count_out));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_out != $past(count_out)) |-> (count_out == $past(count_out) + CNT_W'(1)));

  // R4
  div1_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && ctl_div == 3'b001) |=> (count_out == $past(count_out) + CNT_W'(1)));

  // R7
  irq_needs_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~evt_in) == '0);

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |-> (irq_out == '0));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> $stable(bus_rdata));
endmodule

bind idx_timer_ctl idx_timer_ctl_chk #(.NCPU(NCPU), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .evt_in(evt_in), .irq_out(irq_out),
  .count_out(count_out), .ctl_en(ctl_en), .ctl_div(ctl_div), .irq_mask(irq_mask)
);

// File: tb/tb_idx_timer_ctl.sv
`timescale 1ns/1ps
module tb_idx_timer_ctl;
  localparam int NCPU = 4;
  logic        clk = 0, rst_n = 0;
  logic        bus_req = 0, bus_we = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCPU-1:0] evt_in = '0, irq_out;
  logic [63:0] count_out;

  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  idx_timer_ctl dut (.*);

  always #2.5 clk = ~clk;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic bus_read(logic [3:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      if (bus_req && !bus_we) begin
        @(negedge clk);
        if (exp_q.size() == 0) check("scoreboard underflow", 1, 0);
        else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic run_div(logic [31:0] ctl, int k, int n, string tag);
    logic [63:0] c0;
    bus_write(4'h4, 32'h00);
    c0 = count_out;
    bus_write(4'h0, ctl);
    repeat (n) @(negedge clk);
    check({tag, " count after window"}, count_out, c0 + 64'(n / k));
    bus_write(4'h0, ctl & ~32'h1);
    check({"R6 same-edge disable ", tag}, count_out, c0 + 64'((n + 2) / k));
    repeat (6) @(negedge clk);
    check("R6 hold while stopped", count_out, c0 + 64'((n + 2) / k));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 rdata reset", bus_rdata, 0);
    check("R6 count reset", count_out, 0);
    check("R7 irq reset", irq_out, 0);
    rst_n = 1;
    bus_read(4'h4, 32'h0, "R1 index reset");
    bus_read(4'h0, 32'h100, "R3 control reset");

    bus_write(4'h4, 32'hAB30);
    bus_read(4'h4, 32'h30, "R1 index readback");
    bus_read(4'h0, 32'h0, "R7 mask reset");
    bus_write(4'h0, 32'hFFFF_FFFA);
    bus_read(4'h0, 32'hA, "R7 mask readback");
    bus_read(4'h0, 32'hA, "R10 repeat access same index");
    bus_read(4'h8, 32'h0, "R2 unmapped offset reads zero");
    evt_in = 4'hF;
    @(negedge clk);
    check("R7 irq gating F", irq_out, 4'hA);
    evt_in = 4'h6;
    @(negedge clk);
    check("R7 irq gating 6", irq_out, 4'h2);

    bus_write(4'h4, 32'h00);
    bus_write(4'h0, 32'hFFFF_F2FE);
    bus_read(4'h0, 32'h200, "R3 control field readback");
    check("R6 no count while off", count_out, 0);

    run_div(32'h101, 1, 20, "R4 div1");
    run_div(32'h201, 2, 21, "R4 div2");
    run_div(32'h401, 4, 23, "R4 div4");
    run_div(32'h001, 1, 9,  "R5 div zero");
    run_div(32'h601, 1, 10, "R5 div two bits");

    bus_write(4'h0, 32'h101);
    bus_write(4'h4, 32'h30);
    evt_in = 4'hF;
    bus_write(4'h0, 32'h0);
    check("R8 irq quiet after mask clear", irq_out, 0);
    begin
      logic [63:0] c1;
      c1 = count_out;
      repeat (8) @(negedge clk);
      check("R8 count runs while masked", count_out, c1 + 8);
      check("R8 irq stays quiet", irq_out, 0);
    end

    bus_write(4'h4, 32'h30);
    bus_write(4'h0, 32'h5);
    bus_write(4'h4, 32'h14);
    bus_write(4'h0, 32'hFFFF_FFFF);
    bus_read(4'h0, 32'h0, "R9 unimplemented index reads zero");
    bus_write(4'hC, 32'h0000_0000);
    bus_read(4'h4, 32'h14, "R9 unmapped write leaves index");
    bus_write(4'h4, 32'h00);
    bus_read(4'h0, 32'h101, "R9 control untouched");
    bus_write(4'h4, 32'h30);
    bus_read(4'h0, 32'h5, "R9 mask untouched");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule